// File: doc/BRIEF.md
# Temperature Monitor Measurement Sequencer

This block produces the timing for a temperature monitor's conversions. It divides the bus clock into a conversion tick. After the monitor is switched on, it waits a programmable power-up time. It then launches conversions on command, in one of three modes, and marks the end of each conversion with a one-cycle strobe. A fixed-length counter stands in for the analog converter. The counter length follows a two-bit resolution setting. The block is programmed through a write-only register port. The outputs drive the converter's tick enable and report its busy, start and done events.

Resolution is sampled when a conversion starts. A resolution change therefore takes effect from the next conversion. In continuous mode each conversion starts in the same cycle the previous one ends. In periodic mode conversions start a programmable number of ticks apart. If a conversion is longer than that interval, the next one starts as soon as it ends.

Top module: `tmon_meas_seq`

## Requirements
- R1: During and after reset, `tick_en`, `conv_busy`, `conv_start` and `conv_done` are 0. All register fields reset to 0.
- R2: Ticks depend on the divider register at 0x280 (bit 31 enables it, bits 23:16 hold N) and on the monitor-enable bit. With both set, `tick_en` is high for one cycle every N+1 clocks. If either is clear, no tick occurs.
- R3: A start command has no effect during the power-up phase. The power-up delay is held in bits 23:16 of the register at 0x2B0. With N=0, the first start write that is honoured is the one sampled PUD+3 clock edges after the edge that sampled the enable write.
- R4: In single mode (control bits 25:24 = 0; code 3 behaves the same), one start gives exactly one `conv_start` and one `conv_done`. No further conversion follows.
- R5: A conversion lasts BASE + STEP*(2^res - 1) ticks, where res is control bits 19:18. With N=0, `conv_done` rises exactly that many cycles after `conv_start`. With N>0 the gap lies within [(d-1)(N+1)+1, d(N+1)].
- R6: In continuous mode (bits 25:24 = 1), each new `conv_start` falls in the same cycle as the previous `conv_done`.
- R7: In periodic mode (bits 25:24 = 2), with N=0, consecutive starts are max(P, d) cycles apart. P is bits 23:0 of the register at 0x270.
- R8: Stop (control bit 29) lets a conversion in progress finish with its `conv_done`, then no further start occurs. A stop given while waiting for the next period ends the sequence at once, with no further start or done.
- R9: Clearing monitor enable (control bit 31) aborts everything. `conv_busy` is low two cycles after the write edge, no `conv_done` appears, and ticks stop.
- R10: The control register at 0x200 has aliases: +0x4 sets, +0x8 clears and +0xC toggles the written 1-bits. Start (bit 30) and stop fire on a write, set or toggle that carries a 1, never on the clear alias, and are never stored.
- R11: A start command is ignored while a conversion or a periodic wait is in progress.
- R12: `conv_start` and `conv_done` are single-cycle pulses. `conv_busy` is high from the start cycle and low again in the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register byte address |
| wr_data | input | 32 | Register write data |
| tick_en | output | 1 | Conversion tick enable, one bus-clock cycle per tick |
| conv_busy | output | 1 | A conversion is in progress |
| conv_start | output | 1 | Pulse at conversion launch |
| conv_done | output | 1 | Pulse when the sample is valid |

## Verification
The hardest cases to reach are the ones that depend on the exact cycle in which commands land. These are a start that arrives one edge before power-up ends, and a stop that lands while the sequencer waits between periodic conversions rather than during a conversion. The bench uses a one-clock tick and issues back-to-back writes at counted edges after the enable write. It waits for a done strobe before issuing a stop, so that the stop is known to fall in the wait. Random resolution, divide value and period then check the duration and interval formulas across the mode space.

// File: rtl/tmon_meas_pkg.sv
// Shared types for the measurement sequencer: FSM states, mode codes and
// control-register alias codes. Assumes nothing beyond IEEE 1800-2017.
package tmon_meas_pkg;
    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_PWRUP = 3'd1,
        ST_IDLE  = 3'd2,
        ST_CONV  = 3'd3,
        ST_WAIT  = 3'd4
    } seq_state_t;

    typedef enum logic [1:0] {
        MODE_ONE  = 2'd0,
        MODE_RUN  = 2'd1,
        MODE_PER  = 2'd2,
        MODE_RSVD = 2'd3
    } meas_mode_t;

    typedef enum logic [1:0] {
        AL_WRITE = 2'd0,
        AL_SET   = 2'd1,
        AL_CLR   = 2'd2,
        AL_TOG   = 2'd3
    } alias_t;
endpackage

// File: rtl/tmon_meas_regs.sv
// Write-only register file. The control register supports write, set,
// clear and toggle aliases. Start and stop are one-cycle command pulses
// and are never stored. Assumes a single write per cycle and 32-bit data.
module tmon_meas_regs
    import tmon_meas_pkg::*;
#(
    parameter int          ADDR_W   = 12,
    parameter int          DIV_W    = 8,
    parameter int          PUD_W    = 8,
    parameter int          PER_W    = 24,
    parameter logic [11:0] CTRL_ADR = 12'h200,
    parameter logic [11:0] PER_ADR  = 12'h270,
    parameter logic [11:0] DIV_ADR  = 12'h280,
    parameter logic [11:0] PUD_ADR  = 12'h2B0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output logic              mon_en,
    output meas_mode_t        mode,
    output logic [1:0]        res,
    output logic              div_en,
    output logic [DIV_W-1:0]  div_n,
    output logic [PUD_W-1:0]  pud,
    output logic [PER_W-1:0]  period,
    output logic              cmd_start,
    output logic              cmd_stop
);
    localparam int EN_B   = 31;
    localparam int STA_B  = 30;
    localparam int STO_B  = 29;
    localparam int MODE_L = 24;
    localparam int RES_L  = 18;
    localparam int FLD_L  = 16;

    logic        ctrl_hit;
    alias_t      al;
    logic [31:0] ctrl_old;
    logic [31:0] ctrl_new;

    // Decode control accesses; bits 3:2 pick the alias.
    assign ctrl_hit = wr_en && (wr_addr[ADDR_W-1:4] == CTRL_ADR[ADDR_W-1:4]);
    assign al       = alias_t'(wr_addr[3:2]);

    // Rebuild the stored control view and apply the alias operation.
    always_comb begin
        ctrl_old = '0;
        ctrl_old[EN_B] = mon_en;
        ctrl_old[MODE_L+:2] = mode;
        ctrl_old[RES_L+:2] = res;
        unique case (al)
            AL_WRITE: ctrl_new = wr_data;
            AL_SET:   ctrl_new = ctrl_old | wr_data;
            AL_CLR:   ctrl_new = ctrl_old & ~wr_data;
            default:  ctrl_new = ctrl_old ^ wr_data;
        endcase
    end

    // Commands fire for any alias except clear that carries a 1.
    assign cmd_start = ctrl_hit && (al != AL_CLR) && wr_data[STA_B];
    assign cmd_stop  = ctrl_hit && (al != AL_CLR) && wr_data[STO_B];

    // Stored control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mon_en <= 1'b0;
            mode   <= MODE_ONE;
            res    <= 2'd0;
        end else if (ctrl_hit) begin
            mon_en <= ctrl_new[EN_B];
            mode   <= meas_mode_t'(ctrl_new[MODE_L+:2]);
            res    <= ctrl_new[RES_L+:2];
        end
    end

    // Plain registers: divider, power-up delay and period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_en <= 1'b0;
            div_n  <= '0;
            pud    <= '0;
            period <= '0;
        end else if (wr_en) begin
            if (wr_addr == DIV_ADR[ADDR_W-1:0]) begin
                div_en <= wr_data[EN_B];
                div_n  <= wr_data[FLD_L+:DIV_W];
            end
            if (wr_addr == PUD_ADR[ADDR_W-1:0])
                pud <= wr_data[FLD_L+:PUD_W];
            if (wr_addr == PER_ADR[ADDR_W-1:0])
                period <= wr_data[PER_W-1:0];
        end
    end
endmodule

// File: rtl/tmon_tick_div.sv
// Divide-by-(N+1) tick generator. Produces a one-cycle tick every N+1
// clocks while run is high. The phase restarts whenever run is low.
// Assumes div_n may change at any time; the >= compare avoids a long wrap.
module tmon_tick_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_n,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt >= div_n);

    // Count clocks within one tick period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (cnt >= div_n) cnt <= '0;
        else cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/tmon_conv_timer.sv
// Fixed-duration stand-in for the converter. On go it latches the
// duration for the current resolution and counts ticks. Done is raised in
// the cycle after the final tick. Abort clears it without a done pulse.
// Assumes CONV_BASE >= 1.
module tmon_conv_timer #(
    parameter int CONV_BASE = 2373,
    parameter int CONV_STEP = 2048
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       abort,
    input  logic       go,
    input  logic       tick,
    input  logic [1:0] res,
    output logic       busy,
    output logic       done,
    output logic       finish
);
    localparam int MAX_DUR = CONV_BASE + 7 * CONV_STEP;
    localparam int CW      = $clog2(MAX_DUR + 1);

    logic [CW-1:0] dur;
    logic [CW-1:0] dur_q;
    logic [CW-1:0] cnt;
    logic [CW:0]   cnt_nx;

    // Duration per resolution code: base plus step*(2^res-1).
    always_comb begin
        unique case (res)
            2'd0:    dur = CW'(CONV_BASE);
            2'd1:    dur = CW'(CONV_BASE + CONV_STEP);
            2'd2:    dur = CW'(CONV_BASE + 3 * CONV_STEP);
            default: dur = CW'(CONV_BASE + 7 * CONV_STEP);
        endcase
    end

    assign cnt_nx = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};
    assign finish = busy && tick && (cnt_nx >= {1'b0, dur_q});

    // Conversion progress, done strobe and latched duration.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            cnt   <= '0;
            dur_q <= '0;
        end else begin
            done <= finish;
            if (go) begin
                busy  <= 1'b1;
                cnt   <= '0;
                dur_q <= dur;
            end else if (finish) begin
                busy <= 1'b0;
            end else if (busy && tick) begin
                cnt <= cnt_nx[CW-1:0];
            end
        end
    end
endmodule

// File: rtl/tmon_seq_ctrl.sv
// Measurement FSM: power-up wait, mode handling, period counting and the
// stop request. The go output is combinational and launches the
// conversion timer; conv_start is its registered copy. Assumes the enable
// drop overrides every other transition.
module tmon_seq_ctrl
    import tmon_meas_pkg::*;
#(
    parameter int PUD_W = 8,
    parameter int PER_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mon_en,
    input  meas_mode_t       mode,
    input  logic [PUD_W-1:0] pud,
    input  logic [PER_W-1:0] period,
    input  logic             tick,
    input  logic             cmd_start,
    input  logic             cmd_stop,
    input  logic             finish,
    output seq_state_t       state,
    output logic             go,
    output logic             conv_start
);
    seq_state_t       nxt;
    logic             go_raw;
    logic             stop_now;
    logic             stop_pend;
    logic             per_due;
    logic [PUD_W-1:0] pu_cnt;
    logic [PER_W-1:0] per_cnt;
    logic [PER_W:0]   per_nx;

    assign stop_now = stop_pend || cmd_stop;
    assign per_nx   = {1'b0, per_cnt} + {{PER_W{1'b0}}, tick};
    assign per_due  = per_nx >= {1'b0, period};

    // Next state and launch decision.
    always_comb begin
        nxt    = state;
        go_raw = 1'b0;
        unique case (state)
            ST_OFF:   if (mon_en) nxt = ST_PWRUP;
            ST_PWRUP: if (pu_cnt >= pud) nxt = ST_IDLE;
            ST_IDLE: begin
                if (cmd_start) begin
                    go_raw = 1'b1;
                    nxt    = ST_CONV;
                end
            end
            ST_CONV: begin
                if (finish) begin
                    if (stop_now || mode == MODE_ONE || mode == MODE_RSVD) begin
                        nxt = ST_IDLE;
                    end else if (mode == MODE_RUN || per_due) begin
                        go_raw = 1'b1;
                    end else begin
                        nxt = ST_WAIT;
                    end
                end
            end
            default: begin
                if (stop_now || mode != MODE_PER) begin
                    nxt = ST_IDLE;
                end else if (per_due) begin
                    go_raw = 1'b1;
                    nxt    = ST_CONV;
                end
            end
        endcase
        if (!mon_en) nxt = ST_OFF;
    end

    assign go = go_raw && mon_en;

    // State, start pulse and stop request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_OFF;
            conv_start <= 1'b0;
            stop_pend  <= 1'b0;
        end else begin
            state      <= nxt;
            conv_start <= go;
            if (go || nxt == ST_IDLE || nxt == ST_OFF) stop_pend <= 1'b0;
            else if (cmd_stop && (state == ST_CONV || state == ST_WAIT)) stop_pend <= 1'b1;
        end
    end

    // Power-up tick counter, restarted while off.
    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_PWRUP) pu_cnt <= '0;
        else if (tick && pu_cnt != '1) pu_cnt <= pu_cnt + 1'b1;
    end

    // Period tick counter, restarted at each launch, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || go) per_cnt <= '0;
        else if (tick && per_cnt != '1) per_cnt <= per_cnt + 1'b1;
    end
endmodule

// File: rtl/tmon_meas_seq.sv
// Top of the measurement sequencer: register port, tick divider, FSM and
// fixed-length conversion model. Assumes one bus clock domain.
module tmon_meas_seq
    import tmon_meas_pkg::*;
#(
    parameter int CONV_BASE = 2373,
    parameter int CONV_STEP = 2048,
    parameter int DIV_W     = 8,
    parameter int PUD_W     = 8,
    parameter int PER_W     = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [11:0] wr_addr,
    input  logic [31:0] wr_data,
    output logic        tick_en,
    output logic        conv_busy,
    output logic        conv_start,
    output logic        conv_done
);
    logic             mon_en;
    meas_mode_t       mode;
    logic [1:0]       res;
    logic             div_en;
    logic [DIV_W-1:0] div_n;
    logic [PUD_W-1:0] pud;
    logic [PER_W-1:0] period;
    logic             cmd_start;
    logic             cmd_stop;
    logic             go;
    logic             finish;
    seq_state_t       seq_state;

    tmon_meas_regs #(
        .ADDR_W(12), .DIV_W(DIV_W), .PUD_W(PUD_W), .PER_W(PER_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mon_en(mon_en), .mode(mode), .res(res),
        .div_en(div_en), .div_n(div_n), .pud(pud), .period(period),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop)
    );

    tmon_tick_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(mon_en && div_en),
        .div_n(div_n), .tick(tick_en)
    );

    tmon_seq_ctrl #(.PUD_W(PUD_W), .PER_W(PER_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .mode(mode), .pud(pud),
        .period(period), .tick(tick_en), .cmd_start(cmd_start),
        .cmd_stop(cmd_stop), .finish(finish), .state(seq_state),
        .go(go), .conv_start(conv_start)
    );

    tmon_conv_timer #(.CONV_BASE(CONV_BASE), .CONV_STEP(CONV_STEP)) u_conv (
        .clk(clk), .rst_n(rst_n), .abort(!mon_en), .go(go), .tick(tick_en),
        .res(res), .busy(conv_busy), .done(conv_done), .finish(finish)
    );
endmodule

// File: rtl/tmon_meas_seq_chk.sv
// Property checker for the measurement sequencer, bound to the top.
module tmon_meas_seq_chk
    import tmon_meas_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       mon_en,
    input seq_state_t state,
    input logic       conv_busy,
    input logic       conv_start,
    input logic       conv_done
);
    a_r12_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> conv_busy);
    a_r12_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !conv_start) |-> !conv_busy);
    a_r12_done_had_busy: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> $past(conv_busy));
    a_r9_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en |=> (!conv_busy && !conv_start));
    a_r9_off_idle_conv: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> !conv_busy);
    a_r3_pwrup_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PWRUP) |=> !conv_start);
endmodule

bind tmon_meas_seq tmon_meas_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .state(seq_state),
    .conv_busy(conv_busy), .conv_start(conv_start), .conv_done(conv_done)
);

// File: tb/tmon_meas_seq_bench.sv
module tmon_meas_seq_bench;
    localparam int BASE = 6;
    localparam int STEP = 3;
    localparam logic [11:0] A_CTRL = 12'h200;
    localparam logic [11:0] A_SET  = 12'h204;
    localparam logic [11:0] A_CLR  = 12'h208;
    localparam logic [11:0] A_TOG  = 12'h20C;
    localparam logic [11:0] A_PER  = 12'h270;
    localparam logic [11:0] A_DIV  = 12'h280;
    localparam logic [11:0] A_PUD  = 12'h2B0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        tick_en, conv_busy, conv_start, conv_done;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    int n_start = 0, n_done = 0, n_tick = 0, n_coinc = 0;
    int last_start = 0, prev_start = 0, last_done = 0;
    int last_tick = 0, prev_tick = 0;
    bit finished = 0;

    tmon_meas_seq #(.CONV_BASE(BASE), .CONV_STEP(STEP)) u_tmon_meas_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tick_en(tick_en), .conv_busy(conv_busy),
        .conv_start(conv_start), .conv_done(conv_done)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Event recorder, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (conv_start) begin
                prev_start = last_start; last_start = cyc; n_start++;
            end
            if (conv_done) begin
                last_done = cyc; n_done++;
            end
            if (conv_start && conv_done) n_coinc++;
            if (tick_en) begin
                prev_tick = last_tick; last_tick = cyc; n_tick++;
            end
        end
    end

    function automatic int f_dur(input int r);
        return BASE + STEP * ((1 << r) - 1);
    endfunction

    function automatic int f_interval(input int p, input int d);
        return (p > d) ? p : d;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
        n_checks++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    // Write sampled at the next rising edge; call and return at a negedge.
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_starts(input int target, input int limit);
        for (int i = 0; i < limit && n_start < target; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_dones(input int target, input int limit);
        for (int i = 0; i < limit && n_done < target; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_res(input int r);
        wr(A_CLR, 32'h3 << 18);
        wr(A_SET, 32'(r) << 18);
    endtask

    task automatic set_mode(input int m);
        wr(A_CLR, 32'h3 << 24);
        wr(A_SET, 32'(m) << 24);
    endtask

    task automatic set_div(input int n);
        wr(A_DIV, 32'h8000_0000 | (32'(n) << 16));
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        if (cyc == 150000 && !finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            summary();
        end
    end

    initial begin
        int s, d, t, r, n, p, dur;
        void'($urandom(32'd2718));
        idle(5);
        // R1: reset state
        chk("R1 tick_en in reset", int'(tick_en), 0);
        chk("R1 busy in reset", int'(conv_busy), 0);
        rst_n = 1'b1;
        idle(2);
        chk("R1 start after reset", int'(conv_start), 0);
        chk("R1 done after reset", int'(conv_done), 0);

        // R2: no ticks while divider disabled
        wr(A_SET, 32'h8000_0000);
        idle(20);
        chk("R2 no tick without divider", n_tick, 0);
        set_div(3);
        t = n_tick;
        for (int i = 0; i < 100 && n_tick < t + 4; i++) @(posedge clk);
        @(negedge clk);
        chk("R2 tick spacing N=3", last_tick - prev_tick, 4);
        // R10 clear alias disables monitor, R2 ticks stop
        wr(A_CLR, 32'h8000_0000);
        t = n_tick;
        idle(12);
        chk("R2 R10 no tick after clear", n_tick, t);

        // R3: power-up delay, exact first accepted start
        set_div(0);
        wr(A_PUD, 32'd5 << 16);
        wr(A_SET, 32'h8000_0000);
        idle(5 + 1);
        wr(A_SET, 32'h4000_0000);
        chk("R3 start in power-up ignored", int'(conv_start), 0);
        s = n_start;
        wr(A_SET, 32'h4000_0000);
        chk("R3 first honoured start", int'(conv_start), 1);
        chk("R12 busy at start", int'(conv_busy), 1);
        idle(1);
        chk("R12 start is one cycle", int'(conv_start), 0);

        // R4/R5: single conversion, exact length
        wait_dones(1, 200);
        chk("R5 single duration res0", last_done - last_start, f_dur(0));
        chk("R12 busy low at done", int'(conv_busy), 0);
        s = n_start;
        idle(3 * f_dur(0));
        chk("R4 no restart in single mode", n_start, s);
        chk("R4 one done", n_done, 1);

        // R5: random resolution and divide value
        for (int it = 0; it < 8; it++) begin
            r = $urandom_range(0, 3);
            n = $urandom_range(0, 3);
            dur = f_dur(r);
            set_div(n);
            set_res(r);
            d = n_done;
            wr(A_SET, 32'h4000_0000);
            wait_dones(d + 1, 2000);
            if (n == 0) chk("R5 duration N=0", last_done - last_start, dur);
            else chk_rng("R5 duration N>0", last_done - last_start,
                         (dur - 1) * (n + 1) + 1, dur * (n + 1));
        end
        set_div(0);

        // R6: continuous mode
        set_res(1);
        set_mode(1);
        s = n_start;
        t = n_coinc;
        wr(A_SET, 32'h4000_0000);
        wait_starts(s + 3, 500);
        chk("R6 back-to-back interval", last_start - prev_start, f_dur(1));
        chk("R6 start coincides with done", (n_coinc - t >= 2) ? 1 : 0, 1);
        // R8: stop during conversion finishes it
        d = n_done;
        wr(A_SET, 32'h2000_0000);
        wait_dones(d + 1, 200);
        s = n_start;
        idle(3 * f_dur(1));
        chk("R8 stop lets conversion finish", n_done, d + 1);
        chk("R8 no start after stop", n_start, s);
        chk("R8 busy low after stop", int'(conv_busy), 0);

        // R7: periodic mode with random period and resolution
        set_mode(2);
        for (int it = 0; it < 6; it++) begin
            r = $urandom_range(0, 3);
            p = $urandom_range(1, 40);
            set_res(r);
            wr(A_PER, 32'(p));
            s = n_start;
            wr(A_SET, 32'h4000_0000);
            wait_starts(s + 3, 600);
            chk("R7 periodic interval", last_start - prev_start, f_interval(p, f_dur(r)));
            wr(A_SET, 32'h2000_0000);
            idle(2 * (40 + f_dur(3)));
        end

        // R8/R11: stop during the periodic wait
        set_res(0);
        wr(A_PER, 32'd60);
        s = n_start;
        d = n_done;
        wr(A_SET, 32'h4000_0000);
        wait_dones(d + 1, 200);
        wr(A_SET, 32'h4000_0000);
        idle(3);
        chk("R11 start ignored during wait", n_start, s + 1);
        wr(A_SET, 32'h2000_0000);
        idle(80);
        chk("R8 wait stop: no start", n_start, s + 1);
        chk("R8 wait stop: no done", n_done, d + 1);

        // R11: start ignored during conversion, period unchanged
        s = n_start;
        wr(A_SET, 32'h4000_0000);
        idle(2);
        wr(A_SET, 32'h4000_0000);
        wait_starts(s + 2, 300);
        chk("R11 interval kept after extra start", last_start - prev_start, 60);
        wr(A_SET, 32'h2000_0000);
        idle(80);

        // R9: clearing enable aborts a conversion
        set_mode(0);
        set_res(3);
        d = n_done;
        wr(A_SET, 32'h4000_0000);
        idle(5);
        wr(A_CLR, 32'h8000_0000);
        idle(1);
        chk("R9 busy dropped", int'(conv_busy), 0);
        t = n_tick;
        idle(40);
        chk("R9 no done after abort", n_done, d);
        chk("R9 ticks stopped", n_tick, t);

        // R10: toggle, clear-alias start, plain write with start
        wr(A_TOG, 32'h8000_0000);
        idle(20);
        s = n_start;
        wr(A_CLR, 32'h4000_0000);
        idle(5);
        chk("R10 clear alias never starts", n_start, s);
        wr(A_TOG, 32'h4000_0000);
        idle(1);
        chk("R10 toggle alias starts", n_start, s + 1);
        wait_dones(n_done + 1, 200);
        d = n_done;
        wr(A_CTRL, 32'hC00C_0000);
        wait_dones(d + 1, 200);
        chk("R10 plain write start, res3 kept", last_done - last_start, f_dur(3));
        wr(A_TOG, 32'h8000_0000);
        t = n_tick;
        idle(10);
        chk("R10 toggle disables ticks", n_tick, t);

        summary();
    end
endmodule